// File: doc/BRIEF.md
# Debug Trace Port Mode Controller

This block sets the operating mode of an on-chip debug and trace port that is reached through a JTAG TAP. It has four modes: reset, normal, censored and stop. In reset it holds the port's registers and message queue in reset. It also turns off the test data output, stops accepting the serial test inputs, and tells the chip that the auxiliary trace pins are free for other use.

Outside reset it gates the trace stream and the memory-mapped accesses made through the port. While flash censorship is on, nothing leaves the port, and a refused access is answered with an error status. A request to stop the clocks is accepted only outside reset. It is acknowledged only after any bus transaction being monitored has finished and the message queue is empty.

The TAP state machine, message formatting and the bus master sit outside this block. They connect through the status and request signals below. The mode code is 0 for reset, 1 for normal, 2 for censored and 3 for stop.

Top module: `dbg_port_mode_ctl`

## Requirements
- R1: If `rst_n` is low or `tap_tlr` is high at a rising edge, `mode` is 0 (reset) after that edge. While `mode` is 0, `port_rst_n` is low and `queue_flush` is high; in any other mode `port_rst_n` is high and `queue_flush` is low.
- R2: While `mode` is 0, `tdo_oe`, `jtag_in_en` and `aux_in_use` are all low. In any other mode, `jtag_in_en` and `aux_in_use` are high and `tdo_oe` equals `tap_owner_en`.
- R3: At the first edge where `rst_n` is high and `tap_tlr` is low, the mode leaves reset. It becomes 1 (normal) if `censor_en` is low and 2 (censored) if it is high.
- R4: In modes 1 and 2, with no stop request, the mode follows `censor_en` at each edge: 2 when it is high, 1 when it is low.
- R5: While `censor_en` is high, `trace_out` and `mem_grant` are low in the same cycle, whatever the mode.
- R6: `mem_err` is high for the cycle after an edge at which `mem_req` and `censor_en` were both high outside reset. Otherwise it is low.
- R7: Outside censorship, `trace_out` follows `trace_in` in modes 1 and 3. `mem_grant` follows `mem_req` only in mode 1.
- R8: A `stop_req` sampled in mode 1 or 2 moves the mode to 3 (stop) at that edge. `stop_ack` rises at the first edge in mode 3 where `bus_busy` is low and `queue_empty` is high.
- R9: Once high, `stop_ack` stays high while `stop_req` stays high. After the first edge where `stop_req` is low, the mode returns to 1 or 2 and `stop_ack` is low.
- R10: A `stop_req` that is high while `mode` is 0 does not lead to mode 3 at the next edge. It takes effect only at a later edge that samples it outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Power-on reset, active low, synchronous |
| tap_tlr | input | 1 | TAP is in its test-logic-reset state |
| tap_owner_en | input | 1 | Enable instruction for this port is loaded in the JTAG controller |
| censor_en | input | 1 | Flash censorship is on |
| stop_req | input | 1 | Request to stop the clocks |
| bus_busy | input | 1 | A monitored bus transaction is still in flight |
| queue_empty | input | 1 | Trace message queue is empty |
| trace_in | input | 1 | A trace message is ready to leave the port |
| mem_req | input | 1 | Memory-mapped access requested through the port |
| mode | output | 2 | Current mode: 0 reset, 1 normal, 2 censored, 3 stop |
| port_rst_n | output | 1 | Reset to the port registers, active low |
| queue_flush | output | 1 | Marks the message queue empty |
| tdo_oe | output | 1 | Output enable of the test data output |
| jtag_in_en | output | 1 | Serial test inputs are accepted |
| aux_in_use | output | 1 | Auxiliary trace pins are used by the port |
| trace_out | output | 1 | Trace message is allowed to leave |
| mem_grant | output | 1 | Memory access is forwarded to the bus |
| mem_err | output | 1 | Error status for an access refused under censorship |
| stop_ack | output | 1 | Stop request acknowledged |

## Verification
Mode changes, `stop_ack` and `mem_err` are registered, so each is due one rising edge after the inputs that cause it. The reset-side enables follow from the mode register and change in that same cycle. `trace_out` and `mem_grant` are combinational from the inputs and due in the cycle the input changes. The bench drives all inputs on the falling edge. It checks the combinational gates a moment after driving. It updates its model at the rising edge and compares the registered outputs at the next falling edge, so every check waits exactly the latency its requirement sets.

// File: rtl/dpm_pkg.sv
// Package dpm_pkg
// Purpose: shared mode encoding of the debug port mode controller.
// Assumes: the code values are visible on the top-level mode port, so
//          they must stay fixed.
package dpm_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_RESET  = 2'd0,
        MODE_NORMAL = 2'd1,
        MODE_CENSOR = 2'd2,
        MODE_STOP   = 2'd3
    } dpm_mode_t;

    // Select the running mode from the censorship flag.
    function automatic dpm_mode_t run_mode(input logic censored);
        return censored ? MODE_CENSOR : MODE_NORMAL;
    endfunction

endpackage

// File: rtl/dpm_mode_fsm.sv
// Module dpm_mode_fsm
// Purpose: holds the port mode register and moves between reset,
//          normal, censored and stop.
// Assumes: rst_n and tap_tlr are already synchronous to clk; the stop
//          handshake is handled by dpm_stop_hs, which only watches this
//          register.
module dpm_mode_fsm
    import dpm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tap_tlr,
    input  logic      censor_en,
    input  logic      stop_req,
    output dpm_mode_t mode
);

    dpm_mode_t mode_q;
    dpm_mode_t mode_d;

    // Next-mode selection from the current mode and the inputs.
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_RESET:  mode_d = run_mode(censor_en);
            MODE_NORMAL,
            MODE_CENSOR: mode_d = stop_req ? MODE_STOP : run_mode(censor_en);
            MODE_STOP:   mode_d = stop_req ? MODE_STOP : run_mode(censor_en);
            default:     mode_d = MODE_RESET;
        endcase
        if (tap_tlr) begin
            mode_d = MODE_RESET;
        end
    end

    // Mode register with synchronous power-on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RESET;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign mode = mode_q;

endmodule

// File: rtl/dpm_stop_hs.sv
// Module dpm_stop_hs
// Purpose: stop handshake. It raises the acknowledge once the port is
//          in stop mode, no monitored bus transfer is in flight and the
//          message queue has drained, then holds it until the request
//          goes away.
// Assumes: bus_busy and queue_empty come from logic on the same clock.
module dpm_stop_hs
    import dpm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tap_tlr,
    input  dpm_mode_t mode,
    input  logic      stop_req,
    input  logic      bus_busy,
    input  logic      queue_empty,
    output logic      stop_ack
);

    logic ack_q;
    logic drained;
    logic abort;

    // Pending work is finished when the bus is idle and the queue empty.
    assign drained = !bus_busy && queue_empty;

    // Leaving stop or entering reset drops the handshake.
    assign abort = tap_tlr || (mode != MODE_STOP) || !stop_req;

    // Acknowledge register: set on drain, held, cleared on abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
        end else if (abort) begin
            ack_q <= 1'b0;
        end else if (drained) begin
            ack_q <= 1'b1;
        end
    end

    assign stop_ack = ack_q;

endmodule

// File: rtl/dpm_access_gate.sv
// Module dpm_access_gate
// Purpose: gates the trace stream and memory-mapped accesses by mode
//          and censorship, and registers an error status for an access
//          refused under censorship.
// Assumes: censor_en is stable within a cycle; the gates are
//          combinational so that censorship blocks in the same cycle.
module dpm_access_gate
    import dpm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  dpm_mode_t mode,
    input  logic      censor_en,
    input  logic      trace_in,
    input  logic      mem_req,
    output logic      trace_out,
    output logic      mem_grant,
    output logic      mem_err
);

    logic trace_mode_ok;
    logic mem_mode_ok;
    logic err_q;

    // Trace may leave in normal mode and while draining for stop.
    assign trace_mode_ok = (mode == MODE_NORMAL) || (mode == MODE_STOP);

    // New memory accesses are forwarded only in normal mode.
    assign mem_mode_ok = (mode == MODE_NORMAL);

    // Censorship overrides both gates at once.
    assign trace_out = trace_in && trace_mode_ok && !censor_en;
    assign mem_grant = mem_req && mem_mode_ok && !censor_en;

    // Error status for a refused access, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= mem_req && censor_en && (mode != MODE_RESET);
        end
    end

    assign mem_err = err_q;

endmodule

// File: rtl/dbg_port_mode_ctl.sv
// Module dbg_port_mode_ctl
// Purpose: mode controller of a debug and trace port reached through a
//          JTAG TAP. It drives the port reset, the pin enables, the
//          censorship gates and the stop handshake.
// Assumes: every input is synchronous to clk; rst_n is the power-on
//          reset, low active and synchronous.
module dbg_port_mode_ctl
    import dpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tap_tlr,
    input  logic              tap_owner_en,
    input  logic              censor_en,
    input  logic              stop_req,
    input  logic              bus_busy,
    input  logic              queue_empty,
    input  logic              trace_in,
    input  logic              mem_req,
    output logic [MODE_W-1:0] mode,
    output logic              port_rst_n,
    output logic              queue_flush,
    output logic              tdo_oe,
    output logic              jtag_in_en,
    output logic              aux_in_use,
    output logic              trace_out,
    output logic              mem_grant,
    output logic              mem_err,
    output logic              stop_ack
);

    dpm_mode_t mode_cur;
    logic      in_reset;

    // Mode register.
    dpm_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tap_tlr   (tap_tlr),
        .censor_en (censor_en),
        .stop_req  (stop_req),
        .mode      (mode_cur)
    );

    // Stop handshake.
    dpm_stop_hs u_stop (
        .clk         (clk),
        .rst_n       (rst_n),
        .tap_tlr     (tap_tlr),
        .mode        (mode_cur),
        .stop_req    (stop_req),
        .bus_busy    (bus_busy),
        .queue_empty (queue_empty),
        .stop_ack    (stop_ack)
    );

    // Trace and memory gating.
    dpm_access_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_cur),
        .censor_en (censor_en),
        .trace_in  (trace_in),
        .mem_req   (mem_req),
        .trace_out (trace_out),
        .mem_grant (mem_grant),
        .mem_err   (mem_err)
    );

    // Reset-side enables derived from the registered mode.
    assign in_reset    = (mode_cur == MODE_RESET);
    assign port_rst_n  = !in_reset;
    assign queue_flush = in_reset;
    assign jtag_in_en  = !in_reset;
    assign aux_in_use  = !in_reset;
    assign tdo_oe      = tap_owner_en && !in_reset;
    assign mode        = mode_cur;

endmodule

// File: rtl/dpm_checker.sv
// Module dpm_checker
// Purpose: property checks on the mode controller, bound to the top.
// Assumes: it sees the top-level ports only.
module dpm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tap_tlr,
    input logic       censor_en,
    input logic       stop_req,
    input logic       bus_busy,
    input logic       queue_empty,
    input logic [1:0] mode,
    input logic       tdo_oe,
    input logic       jtag_in_en,
    input logic       aux_in_use,
    input logic       trace_out,
    input logic       mem_grant,
    input logic       stop_ack
);

    // R1: test-logic-reset forces reset mode at the next edge.
    a_r1_tlr_resets: assert property (@(posedge clk) disable iff (!rst_n)
        tap_tlr |=> (mode == 2'd0));

    // R2: pins released while in reset.
    a_r2_pins_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |-> (!tdo_oe && !jtag_in_en && !aux_in_use));

    // R5: censorship blocks trace and memory access.
    a_r5_censor_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        censor_en |-> (!trace_out && !mem_grant));

    // R8: acknowledge only rises after drained status.
    a_r8_ack_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_ack) |-> ($past(!bus_busy && queue_empty) && mode == 2'd3));

    // R9: acknowledge holds while the request holds.
    a_r9_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_ack && stop_req && !tap_tlr) |=> stop_ack);

    // R10: no direct step from reset to stop.
    a_r10_no_stop_from_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |=> (mode != 2'd3));

endmodule

bind dbg_port_mode_ctl dpm_checker u_dpm_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .tap_tlr     (tap_tlr),
    .censor_en   (censor_en),
    .stop_req    (stop_req),
    .bus_busy    (bus_busy),
    .queue_empty (queue_empty),
    .mode        (mode),
    .tdo_oe      (tdo_oe),
    .jtag_in_en  (jtag_in_en),
    .aux_in_use  (aux_in_use),
    .trace_out   (trace_out),
    .mem_grant   (mem_grant),
    .stop_ack    (stop_ack)
);

// File: tb/dbg_port_mode_ctl_test.sv
module dbg_port_mode_ctl_test;

    logic clk = 1'b0;
    logic rst_n, tap_tlr, tap_owner_en, censor_en, stop_req;
    logic bus_busy, queue_empty, trace_in, mem_req;
    logic [1:0] mode;
    logic port_rst_n, queue_flush, tdo_oe, jtag_in_en, aux_in_use;
    logic trace_out, mem_grant, mem_err, stop_ack;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Model state, taken from the requirements.
    logic [1:0] m_mode;
    logic       m_ack;
    logic       m_err;

    always #10 clk = ~clk;

    dbg_port_mode_ctl uut (
        .clk(clk), .rst_n(rst_n), .tap_tlr(tap_tlr), .tap_owner_en(tap_owner_en),
        .censor_en(censor_en), .stop_req(stop_req), .bus_busy(bus_busy),
        .queue_empty(queue_empty), .trace_in(trace_in), .mem_req(mem_req),
        .mode(mode), .port_rst_n(port_rst_n), .queue_flush(queue_flush),
        .tdo_oe(tdo_oe), .jtag_in_en(jtag_in_en), .aux_in_use(aux_in_use),
        .trace_out(trace_out), .mem_grant(mem_grant), .mem_err(mem_err),
        .stop_ack(stop_ack)
    );

    task automatic check(input string req, input string what, input logic [1:0] act, input logic [1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R3/R4/R8/R9/R10: next mode.
    function automatic logic [1:0] nxt_mode(input logic [1:0] m);
        logic [1:0] run;
        run = censor_en ? 2'd2 : 2'd1;
        if (!rst_n || tap_tlr) return 2'd0;
        if (m == 2'd0) return run;
        if (stop_req) return 2'd3;
        return run;
    endfunction

    function automatic logic nxt_ack();
        if (!rst_n || tap_tlr || m_mode != 2'd3 || !stop_req) return 1'b0;
        return m_ack || (!bus_busy && queue_empty);
    endfunction

    // Model update at each rising edge.
    always @(posedge clk) begin
        m_ack  <= nxt_ack();
        m_err  <= rst_n && mem_req && censor_en && (m_mode != 2'd0);
        m_mode <= nxt_mode(m_mode);
    end

    // Compare all outputs against the model.
    task automatic check_all();
        logic rs;
        rs = (m_mode == 2'd0);
        check("R1", "mode", mode, m_mode);
        check("R1", "port_rst_n", port_rst_n, !rs);
        check("R1", "queue_flush", queue_flush, rs);
        check("R2", "jtag_in_en", jtag_in_en, !rs);
        check("R2", "aux_in_use", aux_in_use, !rs);
        check("R2", "tdo_oe", tdo_oe, tap_owner_en && !rs);
        if (censor_en) begin
            check("R5", "trace_out", trace_out, 1'b0);
            check("R5", "mem_grant", mem_grant, 1'b0);
        end else begin
            check("R7", "trace_out", trace_out, trace_in && (m_mode == 2'd1 || m_mode == 2'd3));
            check("R7", "mem_grant", mem_grant, mem_req && m_mode == 2'd1);
        end
        check("R6", "mem_err", mem_err, m_err);
        check("R8", "stop_ack", stop_ack, m_ack);
    endtask

    task automatic cyc(input logic r, input logic t, input logic c, input logic s,
                       input logic b, input logic q, input logic tr, input logic mr);
        @(negedge clk);
        rst_n = r; tap_tlr = t; censor_en = c; stop_req = s;
        bus_busy = b; queue_empty = q; trace_in = tr; mem_req = mr;
        #1 check_all();
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0; tap_tlr = 1; tap_owner_en = 1; censor_en = 0; stop_req = 0;
        bus_busy = 0; queue_empty = 1; trace_in = 0; mem_req = 0;
        m_mode = 2'd0; m_ack = 0; m_err = 0;
        repeat (3) @(posedge clk);
        // Reset state (R1, R2).
        cyc(0, 1, 0, 0, 0, 1, 1, 1);
        check("R1", "reset mode", mode, 2'd0);
        // R10: stop request while in reset, then leave reset (R3).
        cyc(1, 0, 0, 1, 0, 1, 1, 1);
        check("R10", "first exit", mode, 2'd0);
        cyc(1, 0, 0, 1, 1, 0, 1, 0);
        check("R3", "left reset to normal", mode, 2'd1);
        // R8: stop with busy bus, drain slowly.
        cyc(1, 0, 0, 1, 1, 0, 1, 0);
        check("R8", "in stop", mode, 2'd3);
        cyc(1, 0, 0, 1, 0, 0, 1, 0);
        check("R8", "no ack while queue busy", stop_ack, 1'b0);
        cyc(1, 0, 0, 1, 0, 1, 0, 0);
        check("R8", "no ack yet", stop_ack, 1'b0);
        cyc(1, 0, 0, 1, 1, 0, 0, 0);
        check("R8", "ack after drain", stop_ack, 1'b1);
        cyc(1, 0, 0, 0, 1, 0, 0, 0);
        check("R9", "ack held", stop_ack, 1'b1);
        cyc(1, 0, 1, 0, 0, 1, 1, 1);
        check("R9", "back to run", mode, 2'd1);
        check("R9", "ack cleared", stop_ack, 1'b0);
        // R4/R6: censored with memory request.
        cyc(1, 0, 1, 0, 0, 1, 1, 1);
        check("R4", "censored mode", mode, 2'd2);
        check("R6", "err after refused", mem_err, 1'b1);
        // R3 censored exit from reset via TAP reset.
        cyc(1, 1, 1, 0, 0, 1, 0, 0);
        cyc(1, 0, 1, 0, 0, 1, 0, 0);
        check("R1", "tlr reset", mode, 2'd0);
        cyc(1, 0, 1, 0, 0, 1, 0, 0);
        check("R3", "left reset to censored", mode, 2'd2);
        // Random phase.
        for (int i = 0; i < 4000; i++) begin
            logic s;
            s = ($urandom_range(0, 9) < 7) ? stop_req : ~stop_req;
            @(negedge clk);
            rst_n        = ($urandom_range(0, 199) != 0);
            tap_tlr      = ($urandom_range(0, 99) == 0);
            tap_owner_en = ($urandom_range(0, 9) != 0);
            censor_en    = ($urandom_range(0, 19) == 0) ? ~censor_en : censor_en;
            stop_req     = s;
            bus_busy     = $urandom_range(0, 1);
            queue_empty  = $urandom_range(0, 2) != 0;
            trace_in     = $urandom_range(0, 1);
            mem_req      = $urandom_range(0, 1);
            #1 check_all();
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule